// File: doc/BRIEF.md
# Prescaled Watchdog Timer

The block is a bus-mapped watchdog. A 16-bit down-counter is decremented by a slow tick made in two stages: a programmable prescaler (ratio 1 to 256, stored as ratio minus one) followed by a selectable power-of-two divider (16, 32, 64 or 128). When the counter steps from one to zero the timer expires. On expiry it can raise a sticky interrupt level, send a one-cycle system reset pulse, or do both, each under its own enable. On the next tick it reloads from a separate reload register and keeps counting. Software keeps the system alive by writing the count register, which loads the live counter at once.

A small state machine follows the counter. `ST_HALT` holds while the run bit is clear, and run going high moves it to `ST_RUN`. In `ST_RUN` the counter steps on each tick. A tick that takes the count from one to zero, with no count write in that cycle, moves it to `ST_FIRE`. `ST_FIRE` lasts exactly one cycle and drives the expiry actions. From there it goes back to `ST_RUN`, or to `ST_HALT` if run has been cleared. Clearing run in `ST_RUN` also returns it to `ST_HALT`. Software stops the watchdog by clearing the run and reset-enable bits and leaving the other control fields as they are.

Register addresses: 0 control, 1 reload, 2 live count, 3 status.

Top module: `wdog_timer`

## Requirements
- R1: After reset, control reads 0, reload and count read 0x8000, status reads 0, and both `irq_o` and `sys_rst_o` are low.
- R2: The control word holds run enable in bit 0, interrupt enable in bit 1, reset enable in bit 2, divider select in bits 4:3 (divide by 16 << select) and the prescaler field (ratio minus one) in bits 15:8. Unused bits read 0. The reload register keeps bits 15:0.
- R3: While running, the counter drops by one every (prescale field + 1) * (16 << select) cycles. The first drop comes that many cycles after the write that set run.
- R4: While run is clear, the counter holds its value.
- R5: A count write loads bits 15:0 into the counter, visible on the next cycle. It also restarts the scaling phase, so the next drop comes a full period after that write.
- R6: When the counter steps from one to zero with reset enable set, `sys_rst_o` is high for exactly the one cycle after that edge.
- R7: When the counter steps from one to zero with interrupt enable set, status bit 0 and `irq_o` go high one cycle after the pulse cycle. They stay high until status is written with bit 0 set. Writing 0 has no effect. With interrupt enable clear, an expiry leaves `irq_o` low.
- R8: With reset enable clear, an expiry produces no reset pulse.
- R9: On the tick after the counter reaches zero, it loads the reload value and counting continues.
- R10: Writing the reload register does not change the live count.
- R11: Divider select 3 with prescale field 1 gives a period of 256 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| irq_o | output | 1 | Sticky interrupt request level |
| sys_rst_o | output | 1 | One-cycle system reset pulse |

## Verification
The bench times every counter step and the expiry to the exact cycle. A scaler that is off by one, or that keeps its phase across a keep-alive write, therefore shows up as a count one cycle early or late. It checks that the reset pulse is one cycle wide, so a design that holds it high for the whole zero period fails. It checks that the interrupt survives a status write of 0 and does not fire when disabled. The wrap from zero to the reload value is also checked, which catches a counter that wraps to 0xFFFF or stalls at zero.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
    localparam int PSC_W  = 8;
    localparam int DSEL_W = 2;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_RELOAD = 2'd1;
    localparam logic [ADDR_W-1:0] A_COUNT  = 2'd2;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd3;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } wd_state_e;

    typedef struct packed {
        logic [PSC_W-1:0]  psc;
        logic [DSEL_W-1:0] div_sel;
        logic              rst_en;
        logic              irq_en;
        logic              run_en;
    } ctrl_t;
endpackage

// File: rtl/wdt_scaler.sv
`timescale 1ns/1ps
module wdt_scaler
    import wdt_pkg::*;
#(
    parameter int DIV_BASE_LOG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [PSC_W-1:0]  psc,
    input  logic [DSEL_W-1:0] div_sel,
    output logic              tick
);
    localparam int NUM_DIV   = 2 ** DSEL_W;
    localparam int DIV_CNT_W = DIV_BASE_LOG + NUM_DIV - 1;

    logic [PSC_W-1:0]     pre_cnt;
    logic [DIV_CNT_W-1:0] div_cnt;
    logic                 pre_hit;
    logic [NUM_DIV-1:0]   div_hit;

    assign pre_hit = run && (pre_cnt == psc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (!run || restart) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else begin
            pre_cnt <= pre_hit ? '0 : pre_cnt + PSC_W'(1);
            if (pre_hit) div_cnt <= div_cnt + DIV_CNT_W'(1);
        end
    end

    // Each selectable ratio watches a wider slice of the divider count.
    for (genvar s = 0; s < NUM_DIV; s++) begin : g_div
        assign div_hit[s] = &div_cnt[DIV_BASE_LOG+s-1:0];
    end

    assign tick = pre_hit && div_hit[div_sel];
endmodule

// File: rtl/wdt_fsm.sv
`timescale 1ns/1ps
module wdt_fsm
    import wdt_pkg::*;
#(
    parameter int             CNT_W       = 16,
    parameter logic [CNT_W-1:0] RESET_COUNT = 16'h8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             fire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    wd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (run) state_d = ST_RUN;
            ST_RUN: begin
                if (!run)                                   state_d = ST_HALT;
                else if (tick && !load && cnt_q == ONE)     state_d = ST_FIRE;
            end
            ST_FIRE: state_d = run ? ST_RUN : ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    always_comb begin
        fire = (state_q == ST_FIRE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RESET_COUNT;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && tick) begin
            cnt_q <= (cnt_q == '0) ? reload_val : cnt_q - ONE;
        end
    end
endmodule

// File: rtl/wdt_regs.sv
`timescale 1ns/1ps
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int               DATA_W      = 32,
    parameter int               CNT_W       = 16,
    parameter logic [CNT_W-1:0] RESET_COUNT = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              fire,
    input  logic [CNT_W-1:0]  cnt_q,
    output ctrl_t             ctrl_q,
    output logic [CNT_W-1:0]  reload_q,
    output logic              cnt_load,
    output logic              irq_flag
);
    localparam int CTRL_LO_W = 3 + DSEL_W;
    localparam int PSC_LSB   = 8;

    logic wr_ctrl, wr_reload, wr_status;

    assign wr_ctrl   = bus_en && bus_wr && (bus_addr == A_CTRL);
    assign wr_reload = bus_en && bus_wr && (bus_addr == A_RELOAD);
    assign cnt_load  = bus_en && bus_wr && (bus_addr == A_COUNT);
    assign wr_status = bus_en && bus_wr && (bus_addr == A_STATUS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            reload_q <= RESET_COUNT;
            irq_flag <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.psc     <= bus_wdata[PSC_LSB+PSC_W-1:PSC_LSB];
                ctrl_q.div_sel <= bus_wdata[CTRL_LO_W-1:3];
                ctrl_q.rst_en  <= bus_wdata[2];
                ctrl_q.irq_en  <= bus_wdata[1];
                ctrl_q.run_en  <= bus_wdata[0];
            end
            if (wr_reload) reload_q <= bus_wdata[CNT_W-1:0];
            // An expiry in the same cycle as a clear wins.
            if (fire && ctrl_q.irq_en)        irq_flag <= 1'b1;
            else if (wr_status && bus_wdata[0]) irq_flag <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL: begin
                bus_rdata[PSC_LSB+PSC_W-1:PSC_LSB] = ctrl_q.psc;
                bus_rdata[CTRL_LO_W-1:0] = {ctrl_q.div_sel, ctrl_q.rst_en,
                                            ctrl_q.irq_en, ctrl_q.run_en};
            end
            A_RELOAD: bus_rdata[CNT_W-1:0] = reload_q;
            A_COUNT:  bus_rdata[CNT_W-1:0] = cnt_q;
            default:  bus_rdata[0]         = irq_flag;
        endcase
    end
endmodule

// File: rtl/wdog_timer.sv
`timescale 1ns/1ps
module wdog_timer
    import wdt_pkg::*;
#(
    parameter int               DATA_W       = 32,
    parameter int               CNT_W        = 16,
    parameter int               DIV_BASE_LOG = 4,
    parameter logic [CNT_W-1:0] RESET_COUNT  = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              sys_rst_o
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_load;
    logic             tick;
    logic             fire;
    logic             irq_flag;
    logic             run_en;
    logic             rst_en;

    assign run_en = ctrl_q.run_en;
    assign rst_en = ctrl_q.rst_en;

    wdt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .RESET_COUNT(RESET_COUNT)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fire(fire), .cnt_q(cnt_q), .ctrl_q(ctrl_q), .reload_q(reload_q),
        .cnt_load(cnt_load), .irq_flag(irq_flag)
    );

    wdt_scaler #(.DIV_BASE_LOG(DIV_BASE_LOG)) u_scaler (
        .clk(clk), .rst_n(rst_n), .run(run_en), .restart(cnt_load),
        .psc(ctrl_q.psc), .div_sel(ctrl_q.div_sel), .tick(tick)
    );

    wdt_fsm #(.CNT_W(CNT_W), .RESET_COUNT(RESET_COUNT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .run(run_en), .tick(tick),
        .load(cnt_load), .load_val(bus_wdata[CNT_W-1:0]),
        .reload_val(reload_q), .cnt_q(cnt_q), .fire(fire)
    );

    assign irq_o     = irq_flag;
    assign sys_rst_o = fire && rst_en;
endmodule

// File: rtl/wdt_checker.sv
`timescale 1ns/1ps
module wdt_checker #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq_o,
    input logic              sys_rst_o,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              run_en,
    input logic              rst_en
);
    logic cnt_wr, clr_wr;
    assign cnt_wr = bus_en && bus_wr && (bus_addr == 2'd2);
    assign clr_wr = bus_en && bus_wr && (bus_addr == 2'd3) && bus_wdata[0];

    assert_step_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && cnt_q != '0) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - CNT_W'(1)));

    assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !cnt_wr) |=> $stable(cnt_q));

    assert_keepalive_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == $past(bus_wdata[CNT_W-1:0])));

    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |=> !sys_rst_o);

    assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_wr) |=> irq_o);

    assert_no_pulse_unarmed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> rst_en);
endmodule

bind wdog_timer wdt_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_wdt_checker (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_o(irq_o),
    .sys_rst_o(sys_rst_o), .cnt_q(cnt_q), .run_en(run_en), .rst_en(rst_en)
);

// File: tb/test_wdog_timer.sv
`timescale 1ns/1ps
module test_wdog_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        sys_rst_o;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    wdog_timer i_wdog_timer (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .sys_rst_o(sys_rst_o)
    );

    // {addr, write data, expected read-back}
    localparam logic [65:0] VEC [6] = '{
        {2'd0, 32'hFFFF_FFE6, 32'h0000_FF06},
        {2'd0, 32'h0000_5A18, 32'h0000_5A18},
        {2'd1, 32'hABCD_1234, 32'h0000_1234},
        {2'd0, 32'h0000_0000, 32'h0000_0000},
        {2'd1, 32'h0000_FFFF, 32'h0000_FFFF},
        {2'd2, 32'h1234_0042, 32'h0000_0042}
    };

    function automatic logic [31:0] ctrl_word(input logic [7:0] psc, input logic [1:0] dsel,
                                              input logic rst_en, input logic irq_en,
                                              input logic run);
        return {16'h0, psc, 3'b000, dsel, rst_en, irq_en, run};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] held;
        int pulses;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        bus_read(2'd0, rd); check("R1 ctrl", rd, 32'h0);
        bus_read(2'd1, rd); check("R1 reload", rd, 32'h8000);
        bus_read(2'd2, rd); check("R1 count", rd, 32'h8000);
        bus_read(2'd3, rd); check("R1 status", rd, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        check("R1 rst", {31'b0, sys_rst_o}, 32'h0);

        // R2 / R5 register table
        for (int i = 0; i < 6; i++) begin
            bus_write(VEC[i][65:64], VEC[i][63:32]);
            bus_read(VEC[i][65:64], rd);
            check((VEC[i][65:64] == 2'd2) ? "R5 load" : "R2 readback", rd, VEC[i][31:0]);
        end

        // R10 reload write leaves count alone
        bus_write(2'd1, 32'h0000_0005);
        bus_read(2'd2, rd); check("R10 count kept", rd, 32'h0042);

        // R3 R6 R7 R9: prescale 1, divide 16, both actions
        bus_write(2'd2, 32'd3);
        bus_write(2'd0, ctrl_word(8'd0, 2'd0, 1'b1, 1'b1, 1'b1));
        step(15); bus_read(2'd2, rd); check("R3 before first tick", rd, 32'd3);
        step(1);  bus_read(2'd2, rd); check("R3 first tick", rd, 32'd2);
        step(31); bus_read(2'd2, rd); check("R3 third tick", rd, 32'd1);
        check("R6 no early pulse", {31'b0, sys_rst_o}, 32'h0);
        step(1);
        check("R6 pulse high", {31'b0, sys_rst_o}, 32'h1);
        bus_read(2'd2, rd); check("R6 count zero", rd, 32'd0);
        check("R7 irq not yet", {31'b0, irq_o}, 32'h0);
        step(1);
        check("R6 pulse one cycle", {31'b0, sys_rst_o}, 32'h0);
        check("R7 irq set", {31'b0, irq_o}, 32'h1);
        step(14); bus_read(2'd2, rd); check("R9 still zero", rd, 32'd0);
        step(1);  bus_read(2'd2, rd); check("R9 reloaded", rd, 32'd5);
        bus_write(2'd3, 32'h0);
        check("R7 write 0 ignored", {31'b0, irq_o}, 32'h1);
        bus_write(2'd3, 32'h1);
        check("R7 cleared", {31'b0, irq_o}, 32'h0);
        bus_write(2'd0, 32'h0);

        // R4 hold while disabled
        bus_read(2'd2, held);
        step(100);
        bus_read(2'd2, rd); check("R4 hold", rd, held);
        check("R4 no pulse", {31'b0, sys_rst_o}, 32'h0);

        // R5 keep-alive restarts phase
        bus_write(2'd2, 32'd10);
        bus_write(2'd0, ctrl_word(8'd0, 2'd0, 1'b0, 1'b0, 1'b1));
        step(19); bus_read(2'd2, rd); check("R5 pre reload", rd, 32'd9);
        bus_write(2'd2, 32'd7);
        step(15); bus_read(2'd2, rd); check("R5 phase restart", rd, 32'd7);
        step(1);  bus_read(2'd2, rd); check("R5 full period", rd, 32'd6);
        bus_write(2'd0, 32'h0);

        // R8 interrupt only
        bus_write(2'd2, 32'd2);
        bus_write(2'd0, ctrl_word(8'd0, 2'd0, 1'b0, 1'b1, 1'b1));
        pulses = 0;
        for (int c = 0; c < 40; c++) begin
            step(1);
            if (sys_rst_o) pulses++;
        end
        check("R8 no reset pulse", pulses, 0);
        check("R8 irq raised", {31'b0, irq_o}, 32'h1);
        bus_write(2'd0, 32'h0);
        bus_write(2'd3, 32'h1);

        // R11 divide 128 with prescale 2, reset only
        bus_write(2'd2, 32'd2);
        bus_write(2'd0, ctrl_word(8'd1, 2'd3, 1'b1, 1'b0, 1'b1));
        step(255); bus_read(2'd2, rd); check("R11 before tick", rd, 32'd2);
        step(1);   bus_read(2'd2, rd); check("R11 tick 256", rd, 32'd1);
        step(255); check("R11 no early pulse", {31'b0, sys_rst_o}, 32'h0);
        step(1);   check("R11 pulse", {31'b0, sys_rst_o}, 32'h1);
        step(1);   check("R11 pulse ends", {31'b0, sys_rst_o}, 32'h0);
        check("R7 irq off when disabled", {31'b0, irq_o}, 32'h0);
        bus_write(2'd0, 32'h0);

        finish_run();
    end
endmodule